// File: doc/BRIEF.md
# Memory-Mapped Serial Transmitter

This block is a transmit-only serial port that sits as a slave on a simple 32-bit register bus. Software configures it through a line-format register and a control register. It then sends characters by writing bytes to a data register. Each accepted byte goes into a transmit queue. A shift stage takes bytes from the queue and sends them on a single output line as frames with one start bit, eight data bits and one stop bit. A separate generator outside the block supplies a one-cycle baud tick. Each bit on the line lasts exactly one tick interval.

Software drives the block by polling. It reads the flag register and waits while the queue-full bit is set, then writes the next byte. A write that arrives while the queue is full is discarded without any error indication. A busy bit in the same register stays set while any byte is still queued or on the wire. It clears only when the last stop bit has finished, so software can wait on it before it changes the line or powers the port down. When the queue is switched off, the block holds a single byte, like a plain holding register.

Top module: `mmio_uart_tx`

## Requirements
- R1: After reset the line output is high, and the flag, line-format and control registers all read zero.
- R2: The line-format register at offset 0x02C keeps bit 4 (queue enable) and bits 6:5 (word length, where 3 means eight bits). The control register at 0x030 keeps bit 0 (port enable), bit 8 (transmit enable) and bit 9 (receive enable, stored only). Both read back what was written, and all other bits read as zero.
- R3: A read of any offset other than 0x018, 0x02C or 0x030 returns zero, and so does a read of the data register at 0x000. A write to an unmapped offset changes nothing and queues nothing.
- R4: A frame is one low start bit, then the eight data bits least significant first, then one high stop bit. Each bit lasts one baud-tick interval and a frame begins on a tick. The line idles high, and a queued byte follows the previous stop bit with no gap.
- R5: Bit 5 of the flag register at 0x018 is set exactly when the queue holds 16 bytes while the queue is enabled. The bit is live: it clears as soon as the shift stage takes a byte.
- R6: A write to the data register at 0x000 made while the full bit is set is discarded, and the bytes already queued are sent unchanged.
- R7: With queue enable at 0, the queue holds one byte. The full bit sets after one accepted write and a second write is dropped. Queue enable should only change while the queue is empty.
- R8: Bit 3 of the flag register (busy) is set while any byte is queued or being shifted. It stays set through the stop bit of the last frame and clears at the tick that ends that stop bit.
- R9: A frame starts only when port enable and transmit enable are both 1. Clearing either one lets the frame in progress finish, and no further frame starts.
- R10: Each accepted data write produces exactly one frame, so writing the same value several times sends it that many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is returned in the same cycle |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| tx_o | output | 1 | Serial output line |

## Verification
Every byte value from 0 to 255 is sent through the polled software loop, with frames decoded at bit centres. This separates bit-order, data-path and framing faults from queue faults. Bursts of 16 and 17 writes made while the port is disabled show where the full flag sets, that the extra write is dropped, and that the full flag clears once a byte has been taken. The same bursts in single-entry mode show the depth-one behaviour. Repeated identical writes, and writes to unmapped offsets, show that one accepted write gives exactly one frame and that other offsets give none. Enable sequences with one enable set at a time, and with the enables cleared in the middle of a frame, show the start condition and the run-to-completion rule. Busy is sampled both inside the last stop bit and just after it.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;
    localparam int CHAR_W = 8;

    localparam logic [BUS_AW-1:0] OFS_DATA = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_FLAG = 12'h018;
    localparam logic [BUS_AW-1:0] OFS_LINE = 12'h02C;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h030;

    localparam int FLAG_FULL_BIT = 5;
    localparam int FLAG_BUSY_BIT = 3;
    localparam int LINE_QEN_BIT  = 4;
    localparam int LINE_WLEN_LO  = 5;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TXE_BIT  = 8;
    localparam int CTRL_RXE_BIT  = 9;

    typedef struct packed {
        logic       qen;
        logic [1:0] wlen;
    } line_cfg_t;

    typedef struct packed {
        logic rxe;
        logic txe;
        logic en;
    } ctrl_cfg_t;
endpackage

// File: rtl/mmio_uart_regs.sv
module mmio_uart_regs
    import mmio_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              q_full,
    input  logic              busy,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              qen,
    output logic              tx_go,
    output logic              push,
    output logic [CHAR_W-1:0] push_data
);
    typedef struct packed {
        line_cfg_t line;
        ctrl_cfg_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic unused_bits;

    assign unused_bits = ^{bus_wdata[BUS_DW-1:10], bus_wdata[7], bus_wdata[3:1]};

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        push_data = bus_wdata[CHAR_W-1:0];
        bus_rdata = '0;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_DATA: push = !q_full;
                OFS_LINE: begin
                    st_d.line.qen  = bus_wdata[LINE_QEN_BIT];
                    st_d.line.wlen = bus_wdata[LINE_WLEN_LO+1:LINE_WLEN_LO];
                end
                OFS_CTRL: begin
                    st_d.ctrl.en  = bus_wdata[CTRL_EN_BIT];
                    st_d.ctrl.txe = bus_wdata[CTRL_TXE_BIT];
                    st_d.ctrl.rxe = bus_wdata[CTRL_RXE_BIT];
                end
                default: ;
            endcase
        end
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_FLAG: begin
                    bus_rdata[FLAG_FULL_BIT] = q_full;
                    bus_rdata[FLAG_BUSY_BIT] = busy;
                end
                OFS_LINE: begin
                    bus_rdata[LINE_QEN_BIT] = st_q.line.qen;
                    bus_rdata[LINE_WLEN_LO+1:LINE_WLEN_LO] = st_q.line.wlen;
                end
                OFS_CTRL: begin
                    bus_rdata[CTRL_EN_BIT]  = st_q.ctrl.en;
                    bus_rdata[CTRL_TXE_BIT] = st_q.ctrl.txe;
                    bus_rdata[CTRL_RXE_BIT] = st_q.ctrl.rxe;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qen   = st_q.line.qen;
    assign tx_go = st_q.ctrl.en && st_q.ctrl.txe;
endmodule

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qen,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t fs_d, fs_q;
    logic [CNT_W-1:0] cap;

    always_comb begin
        fs_d = fs_q;
        if (push) begin
            fs_d.mem[fs_q.wptr] = push_data;
            fs_d.wptr = fs_q.wptr + 1'b1;
        end
        if (pop) fs_d.rptr = fs_q.rptr + 1'b1;
        unique case ({push, pop})
            2'b10:   fs_d.cnt = fs_q.cnt + 1'b1;
            2'b01:   fs_d.cnt = fs_q.cnt - 1'b1;
            default: fs_d.cnt = fs_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign cap   = qen ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full  = fs_q.cnt >= cap;
    assign empty = fs_q.cnt == '0;
    assign count = fs_q.cnt;
    assign head  = fs_q.mem[fs_q.rptr];
endmodule

// File: rtl/mmio_uart_shifter.sv
module mmio_uart_shifter #(
    parameter int DATA_W = 8,
    localparam int FRAME_BITS = DATA_W + 2,
    localparam int BCNT_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_go,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic              active,
    output logic              tx_o
);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  active;
        logic [FRAME_BITS-1:0] sreg;
        logic [BCNT_W-1:0]     bitcnt;
        logic                  line;
    } shift_state_t;

    shift_state_t sh_d, sh_q;
    logic slot_free;

    always_comb begin
        sh_d = sh_q;
        pop = 1'b0;
        slot_free = !sh_q.active || (sh_q.bitcnt == LAST_BIT);
        if (baud_tick) begin
            if (sh_q.active) begin
                if (sh_q.bitcnt == LAST_BIT) begin
                    sh_d.active = 1'b0;
                    sh_d.line   = 1'b1;
                end else begin
                    sh_d.sreg   = {1'b1, sh_q.sreg[FRAME_BITS-1:1]};
                    sh_d.line   = sh_q.sreg[1];
                    sh_d.bitcnt = sh_q.bitcnt + 1'b1;
                end
            end
            if (slot_free && tx_go && have_data) begin
                sh_d.sreg   = {1'b1, head, 1'b0};
                sh_d.line   = 1'b0;
                sh_d.bitcnt = '0;
                sh_d.active = 1'b1;
                pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{active: 1'b0, sreg: '1, bitcnt: '0, line: 1'b1};
        else        sh_q <= sh_d;
    end

    assign active = sh_q.active;
    assign tx_o   = sh_q.line;
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              baud_tick,
    output logic              tx_o
);
    logic              qen, tx_go, push, pop;
    logic              q_full, q_empty, sh_active, busy;
    logic [CHAR_W-1:0] push_data, q_head;
    logic [CNT_W-1:0]  q_count;

    assign busy = sh_active || !q_empty;

    mmio_uart_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .q_full(q_full), .busy(busy), .bus_rdata(bus_rdata),
        .qen(qen), .tx_go(tx_go), .push(push), .push_data(push_data)
    );

    mmio_uart_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(CHAR_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .qen(qen),
        .push(push), .push_data(push_data), .pop(pop),
        .head(q_head), .full(q_full), .empty(q_empty), .count(q_count)
    );

    mmio_uart_shifter #(.DATA_W(CHAR_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_go(tx_go),
        .have_data(!q_empty), .head(q_head),
        .pop(pop), .active(sh_active), .tx_o(tx_o)
    );
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             tx_o,
    input logic             data_wr,
    input logic             q_full,
    input logic [CNT_W-1:0] q_count,
    input logic             sh_active,
    input logic             tx_go,
    input logic             busy
);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R6
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && q_full) |=> (q_count <= $past(q_count)));

    // R9
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_active) |-> $past(tx_go));

    // R4
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_o) |-> $past(baud_tick));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_active |-> tx_o);

    // R8
    busy_falls_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));
endmodule

bind mmio_uart_tx mmio_uart_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_o(tx_o),
    .data_wr(bus_wr && (bus_addr == 12'h000)), .q_full(q_full), .q_count(q_count),
    .sh_active(sh_active), .tx_go(tx_go), .busy(busy)
);

// File: tb/mmio_uart_tx_tb_top.sv
module mmio_uart_tx_tb_top;
    localparam int DIV   = 8;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        baud_tick = 1'b0;
    logic        tx_o;

    int errs = 0, checks = 0;
    logic [7:0] rx_q[$];
    int frame_errs = 0, starts = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mmio_uart_tx #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .baud_tick(baud_tick), .tx_o(tx_o)
    );

    int tcnt = 0;
    always @(negedge clk) begin
        if (tcnt == DIV - 1) begin baud_tick <= 1'b1; tcnt <= 0; end
        else begin baud_tick <= 1'b0; tcnt <= tcnt + 1; end
    end

    // line decoder: samples at bit centres
    int mcnt = 0;
    bit in_fr = 0;
    logic [9:0] fbits;
    always @(negedge clk) begin
        if (!rst_n) in_fr = 0;
        else if (!in_fr) begin
            if (tx_o == 1'b0) begin in_fr = 1; mcnt = 0; starts++; end
        end else begin
            mcnt++;
            if (mcnt % DIV == DIV / 2) begin
                fbits[mcnt / DIV] = tx_o;
                if (mcnt / DIV == 9) begin
                    if (fbits[0] != 1'b0 || fbits[9] != 1'b1) frame_errs++;
                    rx_q.push_back(fbits[8:1]);
                    in_fr = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] f;
        for (int i = 0; i < 40000; i++) begin
            rd(12'h018, f);
            if (f[3] == 1'b0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic quiet(input int frames);
        repeat (frames * 10 * DIV) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_o == 1'b1, "R1 line idle", {31'b0, tx_o}, 1);
        rd(12'h018, r); chk(r == 0, "R1 flags", r, 0);
        rd(12'h02C, r); chk(r == 0, "R1 line-format", r, 0);
        rd(12'h030, r); chk(r == 0, "R1 control", r, 0);

        // R2 readback masks
        wr(12'h02C, 32'hFFFF_FFFF); rd(12'h02C, r); chk(r == 32'h70, "R2 line-format mask", r, 32'h70);
        wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, r); chk(r == 32'h301, "R2 control mask", r, 32'h301);
        wr(12'h030, 32'h0); wr(12'h02C, 32'h70);
        rd(12'h030, r); chk(r == 0, "R2 control cleared", r, 0);

        // R3 unmapped offsets and data read
        wr(12'h004, 32'hAB); wr(12'h01C, 32'hCD); wr(12'h034, 32'h1);
        rd(12'h004, r); chk(r == 0, "R3 unmapped read 0x004", r, 0);
        rd(12'h034, r); chk(r == 0, "R3 unmapped read 0x034", r, 0);
        rd(12'h000, r); chk(r == 0, "R3 data read", r, 0);
        rd(12'h018, r); chk(r == 0, "R3 nothing queued", r, 0);
        rd(12'h02C, r); chk(r == 32'h70, "R3 line-format untouched", r, 32'h70);
        wr(12'h030, 32'h101); quiet(2);
        chk(rx_q.size() == 0, "R3 no frame from unmapped write", rx_q.size(), 0);
        wr(12'h030, 32'h0);

        // R5 / R6 full flag and dropped write
        rx_q.delete();
        for (int i = 0; i < DEPTH - 1; i++) wr(12'h000, 32'h10 + i);
        rd(12'h018, r); chk(r[5] == 1'b0, "R5 not full at 15", r, 32'h8);
        chk(r[3] == 1'b1, "R8 busy while queued", r, 32'h8);
        wr(12'h000, 32'h10 + DEPTH - 1);
        rd(12'h018, r); chk(r[5] == 1'b1, "R5 full at 16", r, 32'h28);
        wr(12'h000, 32'hEE);
        wr(12'h030, 32'h101);
        repeat (3 * DIV) @(negedge clk);
        rd(12'h018, r); chk(r[5] == 1'b0, "R5 live full clears after take", r, 32'h8);
        wait (rx_q.size() == DEPTH);
        rd(12'h018, r); chk(r[3] == 1'b1, "R8 busy during last stop bit", r, 32'h8);
        repeat (6) @(negedge clk);
        rd(12'h018, r); chk(r[3] == 1'b0, "R8 busy clear after stop bit", r, 0);
        quiet(2);
        chk(rx_q.size() == DEPTH, "R6 count after drop", rx_q.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk(rx_q[i] == 8'(32'h10 + i), "R6 queued byte intact", rx_q[i], 32'h10 + i);

        // R4 sweep of all byte values with polled writes
        rx_q.delete();
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 4000; k++) begin
                rd(12'h018, r);
                if (r[5] == 1'b0) break;
            end
            wr(12'h000, 32'(v));
        end
        wait_idle();
        chk(rx_q.size() == 256, "R4 sweep frame count", rx_q.size(), 256);
        for (int v = 0; v < 256 && v < rx_q.size(); v++)
            chk(rx_q[v] == 8'(v), "R4 byte value LSB first", rx_q[v], v);
        chk(frame_errs == 0, "R4 start/stop levels", frame_errs, 0);

        // R10 repeated value
        rx_q.delete();
        repeat (3) wr(12'h000, 32'h55);
        wait_idle();
        chk(rx_q.size() == 3, "R10 three frames", rx_q.size(), 3);
        for (int i = 0; i < 3 && i < rx_q.size(); i++)
            chk(rx_q[i] == 8'h55, "R10 repeated byte", rx_q[i], 32'h55);

        // R7 queue disabled
        wr(12'h030, 32'h0); wr(12'h02C, 32'h60);
        rx_q.delete();
        wr(12'h000, 32'hA1);
        rd(12'h018, r); chk(r[5] == 1'b1, "R7 full after one", r, 32'h28);
        wr(12'h000, 32'hB2);
        wr(12'h030, 32'h101);
        wait_idle(); quiet(1);
        chk(rx_q.size() == 1, "R7 single byte sent", rx_q.size(), 1);
        if (rx_q.size() > 0) chk(rx_q[0] == 8'hA1, "R7 held byte", rx_q[0], 32'hA1);
        wr(12'h02C, 32'h70);

        // R9 enable gating
        wr(12'h030, 32'h001);
        rx_q.delete();
        wr(12'h000, 32'h5A);
        quiet(3);
        chk(rx_q.size() == 0, "R9 port enable only", rx_q.size(), 0);
        wr(12'h030, 32'h100); quiet(3);
        chk(rx_q.size() == 0, "R9 transmit enable only", rx_q.size(), 0);
        rd(12'h018, r); chk(r[3] == 1'b1, "R9 byte still pending", r, 32'h8);
        wr(12'h030, 32'h101);
        wait_idle();
        chk(rx_q.size() == 1 && rx_q[0] == 8'h5A, "R9 sent once both set", rx_q.size(), 1);

        wr(12'h030, 32'h0);
        rx_q.delete();
        wr(12'h000, 32'h3C); wr(12'h000, 32'hC3);
        n0 = starts;
        wr(12'h030, 32'h101);
        wait (starts > n0);
        wr(12'h030, 32'h100);
        quiet(4);
        chk(rx_q.size() == 1, "R9 frame in flight completes alone", rx_q.size(), 1);
        if (rx_q.size() > 0) chk(rx_q[0] == 8'h3C, "R9 completed byte", rx_q[0], 32'h3C);
        rd(12'h018, r); chk(r[3] == 1'b1, "R9 second byte held", r, 32'h8);
        wr(12'h030, 32'h101);
        wait_idle();
        chk(rx_q.size() == 2 && rx_q[1] == 8'hC3, "R9 resumes after re-enable", rx_q.size(), 2);
        chk(frame_errs == 0, "R4 framing overall", frame_errs, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule